// File: doc/BRIEF.md
# Dual Mode Timer with Wishbone Register Port

The block holds two 16-bit timer/counters, A and B, each made of a low byte and a high byte. Each timer has four count modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and two independent 8-bit counters. A timer advances on every system clock, or on rising edges of its own external count input. It can run from a software run bit or from an external gate input. All external inputs pass through a synchronizer before they are used.

Software reaches six byte registers through an 8-bit Wishbone slave port with a 3-bit address. A two-state bus machine handles the handshake. In `BUS_IDLE`, a cycle with both cycle and strobe high performs the access on that edge (transition T_REQ). The machine then moves to `BUS_ACK`, where it raises acknowledge for one cycle and returns to idle unconditionally (transition T_DONE). Each timer has an overflow flag. The flag sets on the timer's overflow event and stays set until software writes 0 to it. Either flag raises the interrupt. Timer B also drives a one-cycle overflow pulse.

Top module: `dual_timer_wb`

Register map, used by the requirements:
- Address 0 is the mode register. Bits 1:0 hold the mode of A (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split). Bit 2 selects the external count input for A, and bit 3 enables the gate for A. Bits 7:4 hold the same fields for B.
- Address 1 is the control register. Bit 0 is run A, bit 1 is flag A, bit 4 is run B and bit 5 is flag B. The other bits read 0.
- Addresses 2, 3, 4 and 5 hold the A low byte, A high byte, B low byte and B high byte.

## Requirements
- R1: An access takes place only on a clock edge where bus_cyc and bus_stb are both high. bus_ack is high for exactly the following cycle. Without both signals high there is no ack and no register write.
- R2: Addresses 0 and 2 to 5 read back the last value written. Addresses 6 and 7 read 0, and writes to them change no register. Read data is valid while bus_ack is high.
- R3: The run bits read back as written. Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged and never sets it.
- R4: In mode 1 the pair counts as a 16-bit value. It wraps from 0xFFFF to 0x0000, and the wrap sets the timer's flag.
- R5: In mode 0, bits 4:0 of the low byte count and carry into the high byte, while bits 7:5 of the low byte hold their value. The flag sets when the high byte is 0xFF and the low 5 bits are all ones.
- R6: In mode 2, when the low byte is at 0xFF, the next count loads it from the high byte and sets the flag. The high byte is unchanged.
- R7: In mode 3 both bytes count independently on each count. Only the high-byte wrap sets the flag.
- R8: irq is high while flag A or flag B is set.
- R9: With the gate bit set, a timer counts only while its synchronized gate input is high, whatever its run bit. With the gate bit clear, it counts while its run bit is 1.
- R10: With the external-count bit set, a timer counts once per rising edge of its synchronized count input, not once per system clock.
- R11: b_wrap_pulse is high for one cycle per Timer B overflow event. The event comes from the low byte in mode 2 and from the high byte in modes 0, 1 and 3.
- R12: rst high clears every register, both flags, irq, bus_ack and b_wrap_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Wishbone cycle qualifier |
| bus_stb | input | 1 | Wishbone strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| irq | output | 1 | Interrupt, high while any flag is set |
| cnt_in_a | input | 1 | External count input, Timer A |
| gate_in_a | input | 1 | External gate input, Timer A |
| cnt_in_b | input | 1 | External count input, Timer B |
| gate_in_b | input | 1 | External gate input, Timer B |
| b_wrap_pulse | output | 1 | One-cycle Timer B overflow pulse |

## Verification
A wrong count state is not visible at once. It shows up only when software reads a byte register, or when a wrap moves irq or b_wrap_pulse one cycle after the faulty edge. For this reason each scenario runs the counter for an exact number of clock edges and then compares the byte values and flags it reads back. A stuck bus state shows at bus_ack in the very next cycle. A wrong gate or edge path shows as a count that is off by the synchronizer latency.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [1:0] {
        MODE_13B    = 2'd0,
        MODE_16B    = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } cnt_mode_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_clk;
        cnt_mode_e mode;
    } tmr_cfg_t;

    localparam int CFG_W         = 4;
    localparam int CTRL_STRIDE   = 4;
    localparam int ADR_MODE      = 0;
    localparam int ADR_CTRL      = 1;
    localparam int ADR_BYTE_BASE = 2;

endpackage

// File: rtl/dtmr_sync.sv
module dtmr_sync #(
    parameter int STAGES = 2,
    parameter bit RISE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    localparam int LEN = STAGES + (RISE ? 1 : 0);

    logic [LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LEN-2:0], din};
    end

    generate
        if (RISE) begin : g_rise
            assign q = chain[STAGES-1] & ~chain[STAGES];
        end else begin : g_level
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int BW        = 8,
    parameter int LOW_SPLIT = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          wrap
);
    localparam logic [2*BW-1:0] PAIR_ONE = (2*BW)'(1);
    localparam logic [BW-1:0]   BYTE_ONE = BW'(1);

    logic [BW-1:0] lo_n, hi_n;

    always_comb begin
        lo_n = lo;
        hi_n = hi;
        wrap = 1'b0;
        if (tick) begin
            unique case (mode)
                MODE_13B: begin
                    if (lo[LOW_SPLIT-1:0] == {LOW_SPLIT{1'b1}}) begin
                        lo_n = {lo[BW-1:LOW_SPLIT], {LOW_SPLIT{1'b0}}};
                        hi_n = hi + BYTE_ONE;
                        wrap = (hi == {BW{1'b1}});
                    end else begin
                        lo_n = lo + BYTE_ONE;
                    end
                end
                MODE_16B: begin
                    {hi_n, lo_n} = {hi, lo} + PAIR_ONE;
                    wrap         = ({hi, lo} == {2*BW{1'b1}});
                end
                MODE_RELOAD: begin
                    if (lo == {BW{1'b1}}) begin
                        lo_n = hi;
                        wrap = 1'b1;
                    end else begin
                        lo_n = lo + BYTE_ONE;
                    end
                end
                MODE_SPLIT: begin
                    lo_n = lo + BYTE_ONE;
                    hi_n = hi + BYTE_ONE;
                    wrap = (hi == {BW{1'b1}});
                end
            endcase
        end
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end
endmodule

// File: rtl/dtmr_bus_fsm.sv
module dtmr_bus_fsm
    import dtmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    output logic access,
    output logic ack
);
    bus_state_e state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            BUS_IDLE: if (cyc && stb) state_n = BUS_ACK;
            BUS_ACK:  state_n = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        access = 1'b0;
        ack    = 1'b0;
        unique case (state)
            BUS_IDLE: access = cyc && stb;
            BUS_ACK:  ack    = 1'b1;
        endcase
    end
endmodule

// File: rtl/dual_timer_wb.sv
module dual_timer_wb
    import dtmr_pkg::*;
#(
    parameter int BW          = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_SPLIT   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    output logic              bus_ack,
    output logic              irq,
    input  logic              cnt_in_a,
    input  logic              gate_in_a,
    input  logic              cnt_in_b,
    input  logic              gate_in_b,
    output logic              b_wrap_pulse
);
    localparam int NTMR = 2;
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);

    logic access, wr, wr_cfg, wr_ctrl;
    tmr_cfg_t [NTMR-1:0] cfg_q;
    logic [NTMR-1:0] run_q, flag_q, wrap, tick, gate_en_vec;
    logic [NTMR-1:0] cnt_rise, gate_lvl;
    logic [NTMR-1:0] cnt_in, gate_in;
    logic [NTMR-1:0][BW-1:0] lo_q, hi_q;
    logic [BW-1:0] rd_mux, ctrl_rd;
    logic pulse_q;

    assign cnt_in  = {cnt_in_b, cnt_in_a};
    assign gate_in = {gate_in_b, gate_in_a};

    dtmr_bus_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cyc    (bus_cyc),
        .stb    (bus_stb),
        .access (access),
        .ack    (bus_ack)
    );

    assign wr      = access && bus_we;
    assign wr_cfg  = wr && (bus_addr == A_MODE);
    assign wr_ctrl = wr && (bus_addr == A_CTRL);

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        localparam logic [ADDR_W-1:0] LO_ADR = ADDR_W'(ADR_BYTE_BASE + 2*t);
        localparam logic [ADDR_W-1:0] HI_ADR = ADDR_W'(ADR_BYTE_BASE + 2*t + 1);
        logic cnt_en;

        dtmr_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) u_cnt_sync (
            .clk (clk), .rst (rst), .din (cnt_in[t]), .q (cnt_rise[t])
        );
        dtmr_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) u_gate_sync (
            .clk (clk), .rst (rst), .din (gate_in[t]), .q (gate_lvl[t])
        );

        assign gate_en_vec[t] = cfg_q[t].gate_en;
        assign cnt_en  = gate_en_vec[t] ? gate_lvl[t] : run_q[t];
        assign tick[t] = cnt_en && (cfg_q[t].ext_clk ? cnt_rise[t] : 1'b1);

        dtmr_counter #(.BW(BW), .LOW_SPLIT(LOW_SPLIT)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick[t]),
            .mode  (cfg_q[t].mode),
            .wr_lo (wr && (bus_addr == LO_ADR)),
            .wr_hi (wr && (bus_addr == HI_ADR)),
            .wdata (bus_wdata),
            .lo    (lo_q[t]),
            .hi    (hi_q[t]),
            .wrap  (wrap[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            run_q   <= '0;
            flag_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            for (int t = 0; t < NTMR; t++) begin
                if (wr_cfg)  cfg_q[t] <= tmr_cfg_t'(bus_wdata[CFG_W*t +: CFG_W]);
                if (wr_ctrl) run_q[t] <= bus_wdata[CTRL_STRIDE*t];
                if (wrap[t])      flag_q[t] <= 1'b1;
                else if (wr_ctrl) flag_q[t] <= flag_q[t] & bus_wdata[CTRL_STRIDE*t + 1];
            end
            pulse_q <= wrap[1];
        end
    end

    always_comb begin
        ctrl_rd = '0;
        for (int t = 0; t < NTMR; t++) begin
            ctrl_rd[CTRL_STRIDE*t]     = run_q[t];
            ctrl_rd[CTRL_STRIDE*t + 1] = flag_q[t];
        end
    end

    always_comb begin
        case (bus_addr)
            A_MODE:  rd_mux = cfg_q;
            A_CTRL:  rd_mux = ctrl_rd;
            3'd2:    rd_mux = lo_q[0];
            3'd3:    rd_mux = hi_q[0];
            3'd4:    rd_mux = lo_q[1];
            3'd5:    rd_mux = hi_q[1];
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (access) bus_rdata <= rd_mux;
    end

    assign irq          = |flag_q;
    assign b_wrap_pulse = pulse_q;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_cyc,
    input logic       bus_stb,
    input logic       bus_ack,
    input logic       irq,
    input logic       b_wrap_pulse,
    input logic [1:0] run_vec,
    input logic [1:0] gate_vec,
    input logic [1:0] flag_vec,
    input logic [7:0] lo_a
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack); // R1

    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_cyc && bus_stb)); // R1

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && !run_vec[0] && !gate_vec[0]) |=> $stable(lo_a)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_vec[1] && !bus_cyc) |=> flag_vec[1]); // R3

    AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        b_wrap_pulse |-> irq); // R11
endmodule

bind dual_timer_wb dtmr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_cyc      (bus_cyc),
    .bus_stb      (bus_stb),
    .bus_ack      (bus_ack),
    .irq          (irq),
    .b_wrap_pulse (b_wrap_pulse),
    .run_vec      (run_q),
    .gate_vec     (gate_en_vec),
    .flag_vec     (flag_q),
    .lo_a         (lo_q[0])
);

// File: tb/sim_dual_timer_wb.sv
module sim_dual_timer_wb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ack, irq, b_wrap_pulse;
    logic       cnt_in_a = 1'b0, gate_in_a = 1'b0, cnt_in_b = 1'b0, gate_in_b = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_timer_wb u0 (
        .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq), .cnt_in_a(cnt_in_a), .gate_in_a(gate_in_a),
        .cnt_in_b(cnt_in_b), .gate_in_b(gate_in_b), .b_wrap_pulse(b_wrap_pulse)
    );

    always @(negedge clk) if (!rst && b_wrap_pulse) pulse_cnt++;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        chk("R1 ack on write", {7'b0, bus_ack}, 8'h01);
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk("R1 ack on read", {7'b0, bus_ack}, 8'h01);
        d = bus_rdata;
        bus_cyc = 1'b0; bus_stb = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    // run a timer for exactly 20 count edges; flag bits written as 1 stay untouched
    task automatic run20(input int t);
        bus_write(3'd1, (t == 0) ? 8'h23 : 8'h32);
        repeat (18) @(negedge clk);
        bus_write(3'd1, 8'h22);
    endtask

    task automatic t_reset;
        chk("R12 ack after reset", {7'b0, bus_ack}, 8'h00);
        chk("R12 irq after reset", {7'b0, irq}, 8'h00);
        chk("R12 pulse after reset", {7'b0, b_wrap_pulse}, 8'h00);
        for (int a = 0; a < 6; a++) read_chk("R12 register clear", 3'(a), 8'h00);
    endtask

    task automatic t_regs;
        bus_write(3'd2, 8'hA5);
        bus_write(3'd3, 8'h3C);
        bus_write(3'd4, 8'h5A);
        bus_write(3'd5, 8'hC3);
        bus_write(3'd0, 8'h36);
        read_chk("R2 mode readback", 3'd0, 8'h36);
        read_chk("R2 TLA readback", 3'd2, 8'hA5);
        read_chk("R2 THA readback", 3'd3, 8'h3C);
        read_chk("R2 TLB readback", 3'd4, 8'h5A);
        read_chk("R2 THB readback", 3'd5, 8'hC3);
        bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF);
        read_chk("R2 unused addr 6", 3'd6, 8'h00);
        read_chk("R2 unused addr 7", 3'd7, 8'h00);
        read_chk("R2 no alias write", 3'd2, 8'hA5);
        read_chk("R2 mode untouched", 3'd0, 8'h36);
    endtask

    task automatic t_nocyc;
        bus_cyc = 1'b0; bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h11;
        repeat (3) begin
            @(negedge clk);
            chk("R1 no ack without cyc", {7'b0, bus_ack}, 8'h00);
        end
        bus_cyc = 1'b1; bus_stb = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 no ack without stb", {7'b0, bus_ack}, 8'h00);
        end
        bus_cyc = 1'b0; bus_we = 1'b0;
        read_chk("R1 no write without both", 3'd2, 8'hA5);
    endtask

    task automatic t_mode1_and_flags;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h11);
        bus_write(3'd2, 8'hF0);
        bus_write(3'd3, 8'hFF);
        run20(0);
        read_chk("R4 16-bit low byte", 3'd2, 8'h04);
        read_chk("R4 16-bit high byte", 3'd3, 8'h00);
        read_chk("R4 flag A set", 3'd1, 8'h02);
        chk("R8 irq from flag A", {7'b0, irq}, 8'h01);
        bus_write(3'd4, 8'hF0);
        bus_write(3'd5, 8'hFF);
        pulse_cnt = 0;
        run20(1);
        read_chk("R4 B low byte", 3'd4, 8'h04);
        read_chk("R4 B high byte", 3'd5, 8'h00);
        chk("R11 one pulse mode 1 from high byte", 8'(pulse_cnt), 8'h01);
        read_chk("R3 both flags", 3'd1, 8'h22);
        bus_write(3'd1, 8'h20);
        read_chk("R3 clear flag A only", 3'd1, 8'h20);
        chk("R8 irq from flag B", {7'b0, irq}, 8'h01);
        bus_write(3'd1, 8'h00);
        read_chk("R3 clear flag B", 3'd1, 8'h00);
        chk("R8 irq low with no flags", {7'b0, irq}, 8'h00);
        bus_write(3'd1, 8'h22);
        read_chk("R3 writing 1 does not set flags", 3'd1, 8'h00);
        chk("R8 irq stays low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mode0;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h00);
        bus_write(3'd2, 8'hFE);
        bus_write(3'd3, 8'hFF);
        run20(0);
        read_chk("R5 13-bit low byte keeps bits 7:5", 3'd2, 8'hF2);
        read_chk("R5 13-bit high byte wrapped", 3'd3, 8'h00);
        read_chk("R5 flag A set", 3'd1, 8'h02);
    endtask

    task automatic t_mode2;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h20);
        bus_write(3'd4, 8'hFC);
        bus_write(3'd5, 8'h80);
        pulse_cnt = 0;
        run20(1);
        read_chk("R6 reload low byte", 3'd4, 8'h90);
        read_chk("R6 reload value kept", 3'd5, 8'h80);
        read_chk("R6 flag B set", 3'd1, 8'h20);
        chk("R11 one pulse mode 2 from low byte", 8'(pulse_cnt), 8'h01);
    endtask

    task automatic t_mode3;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h30);
        bus_write(3'd4, 8'hF0);
        bus_write(3'd5, 8'h10);
        pulse_cnt = 0;
        run20(1);
        read_chk("R7 split low byte", 3'd4, 8'h04);
        read_chk("R7 split high byte", 3'd5, 8'h24);
        read_chk("R7 low wrap sets no flag", 3'd1, 8'h00);
        chk("R11 no pulse from low byte in mode 3", 8'(pulse_cnt), 8'h00);
        bus_write(3'd4, 8'h00);
        bus_write(3'd5, 8'hF0);
        pulse_cnt = 0;
        run20(1);
        read_chk("R7 split low byte second", 3'd4, 8'h14);
        read_chk("R7 split high byte second", 3'd5, 8'h04);
        read_chk("R7 high wrap sets flag", 3'd1, 8'h20);
        chk("R11 pulse from high byte in mode 3", 8'(pulse_cnt), 8'h01);
    endtask

    task automatic t_gate;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h09);
        bus_write(3'd2, 8'h00);
        bus_write(3'd3, 8'h00);
        bus_write(3'd1, 8'h01);
        repeat (10) @(negedge clk);
        read_chk("R9 gate low blocks run bit", 3'd2, 8'h00);
        bus_write(3'd1, 8'h00);
        gate_in_a = 1'b1;
        repeat (10) @(negedge clk);
        bus_write(3'd0, 8'h01);
        gate_in_a = 1'b0;
        read_chk("R9 gate high counts with run 0", 3'd2, 8'h09);
    endtask

    task automatic t_ext;
        bus_write(3'd0, 8'h05);
        bus_write(3'd2, 8'h00);
        bus_write(3'd3, 8'h00);
        bus_write(3'd1, 8'h01);
        repeat (5) begin
            cnt_in_a = 1'b1;
            repeat (3) @(negedge clk);
            cnt_in_a = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        bus_write(3'd1, 8'h00);
        read_chk("R10 one count per rising edge", 3'd2, 8'h05);
        read_chk("R10 high byte untouched", 3'd3, 8'h00);
    endtask

    task automatic t_reset_mid;
        bus_write(3'd0, 8'h11);
        bus_write(3'd4, 8'hFE);
        bus_write(3'd5, 8'hFF);
        run20(1);
        chk("R12 irq before reset", {7'b0, irq}, 8'h01);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 irq cleared by reset", {7'b0, irq}, 8'h00);
        for (int a = 0; a < 6; a++) read_chk("R12 reset clears register", 3'(a), 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_nocyc;
        t_mode1_and_flags;
        t_mode0;
        t_mode2;
        t_mode3;
        t_gate;
        t_ext;
        t_reset_mid;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule